// File: doc/BRIEF.md
# E1 Signalling Multiframe Aligner

This block runs behind an E1 frame aligner that has already found time slot 0. Once per frame it receives the time-slot 16 octet together with a one-cycle strobe. A level input tells it whether frame alignment currently holds. From that octet stream it finds the sixteen-frame channel-associated-signalling multiframe. It reports a sync flag and the position of the most recent frame within the multiframe. When it loses the multiframe it raises a one-cycle loss event. When the frame aligner ought to start over, it raises a one-cycle restart request.

Four configuration inputs shape the behaviour. A strict-acquisition bit asks for two more alignment words, each sixteen frames after the previous one, before sync is declared. A timeout bit limits how long the search may last: six multiframes of searching without sync trigger a restart request. A soft-loss bit adds a second loss rule: two adjacent octets whose upper nibble is zero. A restart-enable bit lets a multiframe loss turn into a restart request. The remote multiframe-alarm bit of each accepted alignment octet is passed out as a status bit and has no effect on alignment.

Top module: `cas_mf_align`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `fas_ok` low, `mf_sync`, `mf_cnt`, `rmt_alarm`, `casrc_evt` and `resync_req` are all 0. Any partial search or confirmation is discarded.
- R2: While searching, an octet whose bits [7:4] are 0000 declares sync (strict bit clear) when it meets two conditions. The octet received just before it, since `fas_ok` last rose, must have had nonzero bits [7:4]. The first octet after `fas_ok` rises can never be accepted. After the accepting strobe `mf_sync`=1 and `mf_cnt`=0.
- R3: In sync, `mf_cnt` advances by one modulo 16 on each strobe and holds between strobes. Every sixteenth strobe is the expected alignment frame and gives `mf_cnt`=0, whatever it contains.
- R4: With `cfg_strict`=1, a candidate found as in R2 is confirmed only if the octets 16 and 32 strobes later also have bits [7:4]=0000. Sync is declared on the second of these. A nonzero nibble at either expected position returns the block to searching.
- R5: In sync, two consecutive expected alignment octets with nonzero bits [7:4] drop `mf_sync` and pulse `casrc_evt` for one cycle. A single bad alignment octet followed by a good one causes no loss.
- R6: On a loss from R5 or R7, `resync_req` pulses together with `casrc_evt` only when `cfg_resync_en`=1.
- R7: With `cfg_soft`=1, two consecutive strobes whose bits [7:4] are 0000 while in sync cause a loss as in R5. With `cfg_soft`=0 they cause none.
- R8: With `cfg_tmo_en`=1, the 96th consecutive searching strobe since `fas_ok` rose or since the last timeout pulses `resync_req` for one cycle, unless that strobe achieves sync. A drop of `fas_ok` restarts the count. With `cfg_tmo_en`=0 no timeout request occurs.
- R9: `rmt_alarm` takes bit 2 of each octet that is accepted as an alignment word. Octets at other positions leave it unchanged. Its value never influences alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fas_ok | input | 1 | Frame alignment currently valid |
| ts16_stb | input | 1 | One-cycle strobe, time-slot 16 octet present |
| ts16_oct | input | 8 | Time-slot 16 octet, bit 7 first on the line |
| cfg_strict | input | 1 | Require two further alignment words before sync |
| cfg_tmo_en | input | 1 | Enable search timeout |
| cfg_soft | input | 1 | Enable adjacent-zero-nibble loss rule |
| cfg_resync_en | input | 1 | Let multiframe loss request a frame restart |
| mf_sync | output | 1 | Multiframe alignment held |
| mf_cnt | output | 4 | Position of the last frame in the multiframe, 0 when not in sync |
| rmt_alarm | output | 1 | Remote alarm bit of the last accepted alignment octet |
| casrc_evt | output | 1 | One-cycle multiframe loss event |
| resync_req | output | 1 | One-cycle request to restart frame alignment |

## Verification
The bench sweeps all sixteen multiframe phases, in both normal and strict acquisition. A design that accepted the very first octet after frame sync, or that skipped the previous-octet test, would lock one multiframe early at phase 0. It would also lock onto the second of two adjacent zero nibbles. The loss tests check three things: a lone bad alignment word is survived, a good word clears the error count, and the counter flywheels through a bad word. An off-by-one error count would drop sync too soon or too late. The timeout test counts searching frames across a `fas_ok` drop, and the soft-rule test checks that adjacent zero nibbles are ignored unless the soft bit is set.

// File: rtl/cas_mf_pkg.sv
package cas_mf_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_CONF = 2'd1,
        ST_SYNC = 2'd2
    } cas_st_e;

endpackage

// File: rtl/cas_oct_decode.sv
module cas_oct_decode #(
    parameter int OCT_W   = 8,
    parameter int TAG_W   = 4,
    parameter int ALM_BIT = 2
) (
    input  logic [OCT_W-1:0] oct,
    output logic             tag_zero,
    output logic             alm
);
    localparam int TAG_LSB = OCT_W - TAG_W;

    always_comb begin
        tag_zero = (oct[OCT_W-1:TAG_LSB] == '0);
        alm      = oct[ALM_BIT];
    end

endmodule

// File: rtl/cas_hunt_timer.sv
module cas_hunt_timer #(
    parameter int LIMIT = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic en,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_last;

    always_comb begin
        at_last = (cnt_q == LAST);
        expire  = tick && at_last && en;
        cnt_d   = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (tick)
            cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R8
    AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> cnt_q == '0); // R8

endmodule

// File: rtl/cas_mf_align.sv
module cas_mf_align
    import cas_mf_pkg::*;
#(
    parameter int MF_LEN    = 16,
    parameter int OCT_W     = 8,
    parameter int TAG_W     = 4,
    parameter int ALM_BIT   = 2,
    parameter int TMO_MF    = 6,
    parameter int CONFIRM_N = 2,
    parameter int LOSS_N    = 2,
    localparam int CNT_W    = $clog2(MF_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fas_ok,
    input  logic             ts16_stb,
    input  logic [OCT_W-1:0] ts16_oct,
    input  logic             cfg_strict,
    input  logic             cfg_tmo_en,
    input  logic             cfg_soft,
    input  logic             cfg_resync_en,
    output logic             mf_sync,
    output logic [CNT_W-1:0] mf_cnt,
    output logic             rmt_alarm,
    output logic             casrc_evt,
    output logic             resync_req
);
    localparam int TMO_FRAMES = TMO_MF * MF_LEN;
    localparam int CONF_W     = $clog2(CONFIRM_N + 1);
    localparam int ERR_W      = $clog2(LOSS_N + 1);
    localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(MF_LEN - 1);

    typedef struct packed {
        cas_st_e           st;
        logic [CNT_W-1:0]  pos;
        logic [CONF_W-1:0] conf;
        logic [ERR_W-1:0]  err;
        logic              prev_vld;
        logic              prev_zero;
        logic              alarm;
        logic              evt;
        logic              req;
    } cas_regs_t;

    localparam cas_regs_t REGS_RST = '{
        st: ST_HUNT, pos: '0, conf: '0, err: '0,
        prev_vld: 1'b0, prev_zero: 1'b0, alarm: 1'b0, evt: 1'b0, req: 1'b0
    };

    cas_regs_t r_d, r_q;

    logic tag_zero, oct_alm;
    logic tmo_fire, tmr_tick, tmr_clr;
    logic at_edge, found, lose;

    cas_oct_decode #(
        .OCT_W  (OCT_W),
        .TAG_W  (TAG_W),
        .ALM_BIT(ALM_BIT)
    ) i_dec (
        .oct     (ts16_oct),
        .tag_zero(tag_zero),
        .alm     (oct_alm)
    );

    always_comb begin
        tmr_tick = fas_ok && ts16_stb && (r_q.st != ST_SYNC);
        tmr_clr  = !fas_ok || (r_q.st == ST_SYNC);
    end

    cas_hunt_timer #(
        .LIMIT(TMO_FRAMES)
    ) i_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .tick  (tmr_tick),
        .en    (cfg_tmo_en),
        .expire(tmo_fire)
    );

    always_comb begin
        r_d     = r_q;
        r_d.evt = 1'b0;
        r_d.req = 1'b0;
        at_edge = (r_q.pos == POS_LAST);
        found   = tag_zero && r_q.prev_vld && !r_q.prev_zero;
        lose    = 1'b0;

        if (!fas_ok) begin
            r_d = REGS_RST;
        end else if (ts16_stb) begin
            r_d.prev_vld  = 1'b1;
            r_d.prev_zero = tag_zero;
            r_d.pos       = r_q.pos + 1'b1;
            case (r_q.st)
                ST_HUNT: begin
                    if (found) begin
                        r_d.pos   = '0;
                        r_d.alarm = oct_alm;
                        r_d.conf  = '0;
                        r_d.err   = '0;
                        r_d.st    = cfg_strict ? ST_CONF : ST_SYNC;
                    end else if (tmo_fire) begin
                        r_d.req = 1'b1;
                    end
                end
                ST_CONF: begin
                    if (at_edge) begin
                        if (tag_zero) begin
                            r_d.alarm = oct_alm;
                            if (r_q.conf == CONF_W'(CONFIRM_N - 1))
                                r_d.st = ST_SYNC;
                            else
                                r_d.conf = r_q.conf + 1'b1;
                        end else begin
                            r_d.st = ST_HUNT;
                        end
                    end
                    if (r_d.st != ST_SYNC && tmo_fire) begin
                        r_d.req = 1'b1;
                        r_d.st  = ST_HUNT;
                    end
                end
                ST_SYNC: begin
                    if (at_edge) begin
                        if (tag_zero) begin
                            r_d.err   = '0;
                            r_d.alarm = oct_alm;
                        end else begin
                            r_d.err = r_q.err + 1'b1;
                        end
                    end
                    lose = (at_edge && !tag_zero && r_q.err == ERR_W'(LOSS_N - 1))
                        || (cfg_soft && tag_zero && r_q.prev_zero);
                    if (lose) begin
                        r_d.st  = ST_HUNT;
                        r_d.err = '0;
                        r_d.evt = 1'b1;
                        r_d.req = cfg_resync_en;
                    end
                end
                default: r_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= REGS_RST;
        else
            r_q <= r_d;
    end

    always_comb begin
        mf_sync    = (r_q.st == ST_SYNC);
        mf_cnt     = mf_sync ? r_q.pos : '0;
        rmt_alarm  = r_q.alarm;
        casrc_evt  = r_q.evt;
        resync_req = r_q.req;
    end

    AST_SYNC_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mf_sync) |-> $past(ts16_stb && ts16_oct[OCT_W-1:OCT_W-TAG_W] == '0)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mf_sync && $past(mf_sync) && $past(ts16_stb) |-> mf_cnt == CNT_W'($past(mf_cnt) + 1'b1)); // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mf_sync && $past(mf_sync) && !$past(ts16_stb) |-> $stable(mf_cnt)); // R3
    AST_EVT_DROPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        casrc_evt |-> !mf_sync && $past(mf_sync)); // R5
    AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        casrc_evt |=> !casrc_evt); // R5
    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        casrc_evt |-> resync_req == $past(cfg_resync_en)); // R6
    AST_NO_SYNC_NO_FAS: assert property (@(posedge clk) disable iff (!rst_n)
        !fas_ok |=> !mf_sync && !resync_req && mf_cnt == '0); // R1
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st != 2'd3); // R4

endmodule

// File: tb/test_cas_mf_align.sv
module test_cas_mf_align;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fas_ok = 1'b0;
    logic       ts16_stb = 1'b0;
    logic [7:0] ts16_oct = 8'h00;
    logic       cfg_strict = 1'b0;
    logic       cfg_tmo_en = 1'b0;
    logic       cfg_soft = 1'b0;
    logic       cfg_resync_en = 1'b1;
    logic       mf_sync;
    logic [3:0] mf_cnt;
    logic       rmt_alarm;
    logic       casrc_evt;
    logic       resync_req;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic snap_evt, snap_req;

    always #10 clk = ~clk;

    cas_mf_align i_cas_mf_align (
        .clk          (clk),
        .rst_n        (rst_n),
        .fas_ok       (fas_ok),
        .ts16_stb     (ts16_stb),
        .ts16_oct     (ts16_oct),
        .cfg_strict   (cfg_strict),
        .cfg_tmo_en   (cfg_tmo_en),
        .cfg_soft     (cfg_soft),
        .cfg_resync_en(cfg_resync_en),
        .mf_sync      (mf_sync),
        .mf_cnt       (mf_cnt),
        .rmt_alarm    (rmt_alarm),
        .casrc_evt    (casrc_evt),
        .resync_req   (resync_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // one frame: strobe for a cycle, snapshot the pulses, then an idle cycle
    task automatic send(input logic [7:0] oct);
        @(negedge clk);
        ts16_stb = 1'b1;
        ts16_oct = oct;
        @(negedge clk);
        ts16_stb = 1'b0;
        snap_evt = casrc_evt;
        snap_req = resync_req;
        @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk);
        fas_ok = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R1 sync after fas loss", int'(mf_sync), 0);
        chk("R1 cnt after fas loss", int'(mf_cnt), 0);
        fas_ok = 1'b1;
    endtask

    function automatic logic [7:0] stream(input int i, input int p);
        return (i >= p && (i - p) % 16 == 0) ? 8'h0B : 8'h55;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int s;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset sync", int'(mf_sync), 0);
        chk("R1 reset cnt", int'(mf_cnt), 0);
        chk("R1 reset alarm", int'(rmt_alarm), 0);
        chk("R1 reset evt", int'(casrc_evt), 0);
        chk("R1 reset req", int'(resync_req), 0);
        rst_n = 1'b1;

        // R2 R3 R9: normal acquisition over every phase
        for (int p = 0; p < 16; p++) begin
            restart();
            s = (p == 0) ? 16 : p;
            for (int i = 0; i < 40; i++) begin
                send(stream(i, p));
                chk("R2 sync", int'(mf_sync), (i >= s) ? 1 : 0);
                if (i >= s) chk("R3 cnt", int'(mf_cnt), (i - s) % 16);
                chk("R9 alarm", int'(rmt_alarm), 0);
            end
        end

        // R4: strict acquisition over phases
        cfg_strict = 1'b1;
        for (int p = 1; p < 16; p++) begin
            restart();
            for (int i = 0; i < 50; i++) begin
                send(stream(i, p));
                chk("R4 strict sync", int'(mf_sync), (i >= p + 32) ? 1 : 0);
            end
        end
        // R4: broken confirmation returns to search
        restart();
        for (int i = 0; i < 70; i++) begin
            send((i == 19) ? 8'h55 : stream(i, 3));
            chk("R4 broken confirm", int'(mf_sync), (i >= 67) ? 1 : 0);
        end
        cfg_strict = 1'b0;

        // R2: adjacent zero nibbles while searching
        restart();
        for (int i = 0; i < 20; i++) begin
            send((i <= 1 || i == 17) ? 8'h0B : 8'h55);
            chk("R2 prev nonzero rule", int'(mf_sync), (i >= 17) ? 1 : 0);
        end

        // R5 R6: loss with restart enabled, then disabled
        for (int en = 1; en >= 0; en--) begin
            cfg_resync_en = en[0];
            restart();
            for (int i = 0; i < 85; i++) begin
                send((i == 17 || i == 49 || i == 65) ? 8'h55 : stream(i, 1));
                chk("R5 loss evt", int'(snap_evt), (i == 65) ? 1 : 0);
                chk("R6 loss req", int'(snap_req), (i == 65 && en == 1) ? 1 : 0);
                chk("R5 sync track", int'(mf_sync), (i >= 1 && i < 65) || i >= 81 ? 1 : 0);
                if (i == 17) chk("R3 flywheel cnt", int'(mf_cnt), 0);
            end
        end
        cfg_resync_en = 1'b1;

        // R7: soft rule on and off
        for (int sf = 0; sf < 2; sf++) begin
            cfg_soft = sf[0];
            restart();
            for (int i = 0; i < 20; i++) begin
                send((i == 18) ? 8'h0F : stream(i, 1));
                chk("R7 soft evt", int'(snap_evt), (sf == 1 && i == 18) ? 1 : 0);
                chk("R7 soft sync", int'(mf_sync), (i >= 1 && !(sf == 1 && i >= 18)) ? 1 : 0);
                if (sf == 0 && i == 18) chk("R7 cnt kept", int'(mf_cnt), 1);
            end
        end
        cfg_soft = 1'b0;

        // R8: search timeout
        cfg_tmo_en = 1'b1;
        restart();
        for (int i = 0; i < 200; i++) begin
            send(8'h55);
            chk("R8 timeout req", int'(snap_req), (i == 95 || i == 191) ? 1 : 0);
        end
        restart();
        for (int i = 0; i < 50; i++) begin
            send(8'h55);
            chk("R8 pre-drop req", int'(snap_req), 0);
        end
        restart();
        for (int i = 0; i < 100; i++) begin
            send(8'h55);
            chk("R8 after drop req", int'(snap_req), (i == 95) ? 1 : 0);
        end
        cfg_tmo_en = 1'b0;
        restart();
        for (int i = 0; i < 150; i++) begin
            send(8'h55);
            chk("R8 timeout off", int'(snap_req), 0);
        end

        // R9: alarm bit follows accepted alignment octets only
        restart();
        for (int i = 0; i < 40; i++) begin
            if (i == 1 || i == 17) send(8'h04);
            else if (i == 33) send(8'h0B);
            else send(8'h55);
            chk("R9 alarm sync", int'(mf_sync), (i >= 1) ? 1 : 0);
            chk("R9 alarm value", int'(rmt_alarm), (i >= 1 && i < 33) ? 1 : 0);
        end

        // R1: fas loss in sync clears everything
        @(negedge clk);
        fas_ok = 1'b0;
        @(negedge clk);
        chk("R1 sync dropped", int'(mf_sync), 0);
        chk("R1 alarm cleared", int'(rmt_alarm), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule